// File: doc/BRIEF.md
# Cross-Coil Gauge PWM Generator

This block drives one cross-coil gauge with two pulse-width modulated signals, one for the sine coil and one for the cosine coil. Both sides share one counter that counts enabled clock ticks and wraps every 255 ticks. Each side compares that counter with its own 8-bit code. An output is high from the wrap up to the point where the counter reaches the code, so the duty is the code divided by 255.

Software writes each code into a holding (master) register through a small write port. The working (slave) copy that the comparator uses takes the held code only when the counter wraps, so a change never shortens or stretches a period already under way. A transfer-enable bit in the control register decides whether writes to the holding registers are accepted. Each side also has a dither bit. When it is set, alternate periods use the code plus one, which gives an average duty halfway between two adjacent codes.

Top module: `meter_pwm`

## Requirements
- R1: While `run` is high the shared counter advances by one on each clock with `cnt_tick` high, and wraps to zero after 255 advances, so one PWM period is 255 ticks.
- R2: Within a valid period, a side's output is high for exactly as many ticks as its effective code, starting at the tick where the counter wraps to zero.
- R3: A side whose effective code is 0 stays low for the whole period.
- R4: A code written to a holding register while a period is running has no effect on that period; it takes effect from the next wrap.
- R5: While control bit 0 (transfer enable) is clear, writes to address 0 (sine code) and address 1 (cosine code) are ignored, and the working codes keep their previous values across wraps.
- R6: After `run` rises, both outputs stay low until the first wrap. Dropping `run` clears the counter and forces both outputs low.
- R7: With a side's dither bit set (control bit 1 for sine, bit 2 for cosine), the periods after a start alternate between the plain code and the code plus one, and the first valid period uses the plain code. Dither enables are taken at the wrap, like the codes.
- R8: The code plus one saturates at 255, which holds the output high for the whole period.
- R9: Reset clears both holding registers, both working codes, the control register and all counter state, and holds both outputs low.
- R10: The sine and cosine sides use separate codes and dither bits and do not affect each other.
- R11: While `cnt_tick` is low, the counter and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable; low stops and clears the counter |
| cnt_tick | input | 1 | Count-clock enable, one counter step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 sine code, 1 cosine code, 2 control, 3 unused |
| wr_data | input | 8 | Write data; control uses bit 0 transfer, bit 1 sine dither, bit 2 cosine dither |
| pwm_sin | output | 1 | Sine-coil PWM output |
| pwm_cos | output | 1 | Cosine-coil PWM output |

## Verification
The outputs are decoded directly from registers, so each output reflects the state left by the most recent rising edge. A write presented before edge k is in the holding register after edge k. A working code changes only at the wrap edge, which is the 255th tick edge after `run` rises and every 255th tick edge after that. The bench counts every edge from the cycle in which it raises `run`. It samples at falling edges, skips the 255 samples of the first period (where both outputs must be low), and then counts high samples over windows of exactly 255 samples, so each window lines up with one period and one dither phase.

// File: rtl/meter_pwm_pkg.sv
package meter_pwm_pkg;
  // register map of the write port
  typedef enum logic [1:0] {
    ADDR_SIN  = 2'd0,
    ADDR_COS  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int CTL_XFER = 0;
  localparam int CTL_DSIN = 1;
  localparam int CTL_DCOS = 2;
  localparam int CTL_W    = 3;

  localparam int SIDES = 2;
endpackage

// File: rtl/mpwm_counter.sv
module mpwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         valid,
  output logic         phase
);
  // last count before the wrap: all ones minus one gives a 2**W-1 period
  localparam logic [W-1:0] LAST = {{(W-1){1'b1}}, 1'b0};

  assign ovf = run && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      valid <= 1'b0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      valid <= 1'b0;
      phase <= 1'b0;
    end else if (ovf) begin
      cnt   <= '0;
      valid <= 1'b1;
      // first valid period starts in the no-addition phase
      phase <= valid ? ~phase : 1'b0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mpwm_regs.sv
module mpwm_regs
  import meter_pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_addr,
  input  logic [W-1:0]              wr_data,
  output logic [SIDES-1:0][W-1:0]   mst,
  output logic [SIDES-1:0]          dith,
  output logic                      xfer
);
  logic [CTL_W-1:0] ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
      mst <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADDR_SIN:  if (ctl[CTL_XFER]) mst[0] <= wr_data;
        ADDR_COS:  if (ctl[CTL_XFER]) mst[1] <= wr_data;
        ADDR_CTRL: ctl <= wr_data[CTL_W-1:0];
        default:   ;
      endcase
    end
  end

  assign xfer    = ctl[CTL_XFER];
  assign dith[0] = ctl[CTL_DSIN];
  assign dith[1] = ctl[CTL_DCOS];
endmodule

// File: rtl/mpwm_side.sv
module mpwm_side #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] master,
  input  logic         dith_en,
  input  logic         valid,
  input  logic         phase,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] slave,
  output logic         pwm
);
  logic         dith_q;
  logic [W-1:0] eff;

  // code plus an optional one, held at all ones
  function automatic logic [W-1:0] eff_code(input logic [W-1:0] c, input logic add);
    if (add && (c != '1)) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slave  <= '0;
      dith_q <= 1'b0;
    end else if (load) begin
      slave  <= master;
      dith_q <= dith_en;
    end
  end

  assign eff = eff_code(slave, dith_q && phase);
  assign pwm = valid && (cnt < eff);
endmodule

// File: rtl/meter_pwm.sv
module meter_pwm
  import meter_pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cnt_tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_sin,
  output logic         pwm_cos
);
  logic [W-1:0]            cnt;
  logic                    ovf;
  logic                    valid;
  logic                    phase;
  logic                    xfer;
  logic [SIDES-1:0][W-1:0] mst;
  logic [SIDES-1:0][W-1:0] slave;
  logic [SIDES-1:0]        dith;
  logic [SIDES-1:0]        pwm;

  // named views for the checker
  logic [W-1:0] slave_sin, slave_cos, mst_sin;
  assign slave_sin = slave[0];
  assign slave_cos = slave[1];
  assign mst_sin   = mst[0];

  mpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(cnt_tick),
    .cnt(cnt), .ovf(ovf), .valid(valid), .phase(phase)
  );

  mpwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mst(mst), .dith(dith), .xfer(xfer)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    mpwm_side #(.W(W)) u_side (
      .clk(clk), .rst_n(rst_n), .load(ovf), .master(mst[s]),
      .dith_en(dith[s]), .valid(valid), .phase(phase), .cnt(cnt),
      .slave(slave[s]), .pwm(pwm[s])
    );
  end

  assign pwm_sin = pwm[0];
  assign pwm_cos = pwm[1];
endmodule

// File: rtl/meter_pwm_chk.sv
module meter_pwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         cnt_tick,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] cnt,
  input logic         ovf,
  input logic         valid,
  input logic         phase,
  input logic         xfer,
  input logic [W-1:0] slave_sin,
  input logic [W-1:0] slave_cos,
  input logic [W-1:0] mst_sin,
  input logic         pwm_sin,
  input logic         pwm_cos
);
  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == '0));

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_tick) |=> $stable(cnt));

  // R4
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> ($stable(slave_sin) && $stable(slave_cos)));

  // R5
  xfer_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && !xfer) |=> $stable(mst_sin));

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (!pwm_sin && !pwm_cos));

  // R2
  rise_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_sin) || $rose(pwm_cos)) |-> (cnt == '0));

  // R7
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && valid) |=> (phase != $past(phase)));
endmodule

bind meter_pwm meter_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cnt_tick(cnt_tick),
  .wr_en(wr_en), .wr_addr(wr_addr), .cnt(cnt), .ovf(ovf),
  .valid(valid), .phase(phase), .xfer(xfer), .slave_sin(slave_sin),
  .slave_cos(slave_cos), .mst_sin(mst_sin), .pwm_sin(pwm_sin),
  .pwm_cos(pwm_cos)
);

// File: tb/tb_meter_pwm.sv
`timescale 1ns/1ps
module tb_meter_pwm;
  localparam int PER = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       cnt_tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_sin, pwm_cos;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  meter_pwm dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_tick(cnt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_sin(pwm_sin), .pwm_cos(pwm_cos)
  );

  // vector: sine code, cosine code, control bits {dcos, dsin, xfer}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {8'd100, 8'd200, 3'b001},
    {8'd0,   8'd255, 3'b111},
    {8'd254, 8'd1,   3'b011},
    {8'd128, 8'd0,   3'b101},
    {8'd37,  8'd219, 3'b111},
    {8'd255, 8'd255, 3'b001}
  };

  function automatic int expect_hi(input int code, input bit add);
    int v;
    v = code + (add ? 1 : 0);
    return (v > PER) ? PER : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // count high samples over one period; optional sine write at index wr_at
  task automatic measure(input int wr_at, input logic [7:0] wv,
                         output int hs, output int hc, output int first_low);
    hs = 0; hc = 0; first_low = PER;
    for (int i = 0; i < PER; i++) begin
      if (pwm_sin) hs++;
      else if (first_low == PER) first_low = i;
      if (pwm_cos) hc++;
      if (i == wr_at) begin
        wr_addr = 2'd0; wr_data = wv; wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic start_and_skip(input string req);
    int hs, hc, fl;
    run = 1'b1;
    measure(-1, 8'd0, hs, hc, fl);
    chk(req, hs + hc, 0);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hs, hc, fl;
    logic [7:0] cs, cc;
    logic [2:0] ct;

    repeat (4) @(negedge clk);
    // R9: outputs low under reset
    chk("R9 reset sin", int'(pwm_sin), 0);
    chk("R9 reset cos", int'(pwm_cos), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R6 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      cs = VEC[v][18:11]; cc = VEC[v][10:3]; ct = VEC[v][2:0];
      run = 1'b0;
      @(negedge clk);
      wr(2'd2, {5'd0, ct});
      wr(2'd0, cs);
      wr(2'd1, cc);
      start_and_skip("R6 no pulse before first wrap");
      measure(-1, 8'd0, hs, hc, fl);
      chk("R2 R3 sin plain period", hs, expect_hi(cs, 1'b0));
      chk("R2 R10 cos plain period", hc, expect_hi(cc, 1'b0));
      chk("R2 sin high run starts at wrap", fl, expect_hi(cs, 1'b0));
      measure(-1, 8'd0, hs, hc, fl);
      chk("R7 R8 sin second period", hs, expect_hi(cs, ct[1]));
      chk("R7 R8 R10 cos second period", hc, expect_hi(cc, ct[2]));
    end

    // R4: mid-period write waits for the wrap
    run = 1'b0;
    @(negedge clk);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'd60);
    wr(2'd1, 8'd90);
    start_and_skip("R6 no pulse before first wrap");
    measure(100, 8'd150, hs, hc, fl);
    chk("R4 current period keeps old code", hs, 60);
    measure(-1, 8'd0, hs, hc, fl);
    chk("R4 new code after wrap", hs, 150);
    chk("R10 cos untouched by sin write", hc, 90);

    // R5: writes ignored with transfer disabled; working code kept
    run = 1'b0;
    @(negedge clk);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'd20);
    wr(2'd1, 8'd30);
    start_and_skip("R6 restart low until wrap");
    measure(-1, 8'd0, hs, hc, fl);
    chk("R5 sin write ignored", hs, 150);
    chk("R5 cos write ignored", hc, 90);

    // R11: tick low freezes outputs (sine high at index 10)
    run = 1'b0;
    @(negedge clk);
    wr(2'd2, 8'd1);
    wr(2'd0, 8'd100);
    start_and_skip("R6 no pulse before first wrap");
    repeat (10) @(negedge clk);
    cnt_tick = 1'b0;
    @(negedge clk);
    fl = 0;
    for (int i = 0; i < 30; i++) begin
      if (pwm_sin !== 1'b1) fl++;
      @(negedge clk);
    end
    chk("R11 sin held while tick low", fl, 0);
    cnt_tick = 1'b1;
    // remaining high ticks: 100 - 10 samples already seen
    hs = 0;
    for (int i = 0; i < PER - 10; i++) begin
      if (pwm_sin) hs++;
      @(negedge clk);
    end
    chk("R1 R11 period resumes without loss", hs, 90);

    // R9: reset mid-run clears codes
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 outputs low in reset", int'(pwm_sin | pwm_cos), 0);
    run = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    wr(2'd2, 8'd1);
    start_and_skip("R6 no pulse before first wrap");
    measure(-1, 8'd0, hs, hc, fl);
    chk("R9 sin code cleared", hs, 0);
    chk("R9 cos code cleared", hc, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule